// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic stage of a small 8-bit datapath. One operand always comes from an internal accumulator register. The other operand arrives on a port from whatever register or memory location the surrounding decode logic selects. A one-cycle execute strobe commits the chosen operation. The result is written back into the accumulator, except for compare, which leaves the accumulator as it is.

Every operation also updates five condition flags: sign, zero, parity, auxiliary carry and carry. Each flag is driven on its own pin. The flags are also packed into a byte with fixed bit positions, so that a program can store them or test them as data. Instruction decode, the register file and memory access sit outside the block.

Top module: `acc_alu`

## Requirements
- R1: A synchronous active-high reset clears the accumulator to 0x00 and all five flags to 0, so the flag byte reads 0x02. Reset takes priority over an execute strobe in the same cycle.
- R2: While exec_i is low, the accumulator and all flags keep their values, whatever op_i, opnd_i and cin_i do.
- R3: Results appear on the outputs after the rising edge at which exec_i is high. For op 0 (add) and op 1 (add with carry), the result is A + B (+ cin_i for op 1) modulo 256. Carry is the carry out of bit 7. Auxiliary carry is 1 when A[3:0] + B[3:0] (+ cin_i) exceeds 15.
- R4: For op 2 (subtract) and op 3 (subtract with borrow), the result is A - B (- cin_i for op 3) modulo 256. Carry is 1 when a borrow occurs, that is, when A < B + borrow-in. Auxiliary carry is 1 when A[3:0] + ~B[3:0] + (1 - borrow-in) exceeds 15.
- R5: Op 4 is AND, op 5 is XOR and op 6 is OR, all bitwise. Each of them clears carry. AND sets auxiliary carry to 1, while XOR and OR clear it.
- R6: Op 7 (compare) sets all five flags exactly as op 2 would with the same operands, and leaves the accumulator unchanged.
- R7: For every operation, zero is 1 exactly when the 8-bit result is 0x00, sign equals bit 7 of the result, and parity is 1 when the result holds an even number of one bits. For compare, the result is the difference.
- R8: The flag byte carries sign in bit 7, zero in bit 6, auxiliary carry in bit 4, parity in bit 2 and carry in bit 0. Bit 1 reads 1, bits 5 and 3 read 0, and the byte always agrees with the individual flag pins.
- R9: cin_i has no effect on ops 0, 2 and 4 to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_i | input | 1 | Execute strobe, one operation per cycle while high |
| op_i | input | 3 | Operation select (0 add, 1 add with carry, 2 sub, 3 sub with borrow, 4 AND, 5 XOR, 6 OR, 7 compare) |
| opnd_i | input | 8 | Second operand |
| cin_i | input | 1 | Carry or borrow in, used by ops 1 and 3 only |
| acc_o | output | 8 | Accumulator |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| acf_o | output | 1 | Auxiliary carry flag |
| pf_o | output | 1 | Parity flag |
| cy_o | output | 1 | Carry / borrow flag |
| flags_o | output | 8 | Packed flag byte |

## Verification
Two functions can fall in the same cycle: a synchronous reset and an execute strobe. The bench first builds a nonzero accumulator with flags set, then raises rst together with exec_i and an add that would change the result. It expects 0x00 and flag byte 0x02 after that edge, because reset wins. Compare is a second case where two effects share one edge: the flags update while the accumulator holds. Compare is judged by checking that the flags match a subtract and that the accumulator value is unchanged.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_XOR = 3'd5,
    OP_OR  = 3'd6,
    OP_CMP = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         cy_o,
  output logic         hc_o
);
  localparam int HI = W - NIB;

  logic [W-1:0]  bx;
  logic          c0;
  logic [NIB:0]  lo;
  logic [HI:0]   hi;

  always_comb begin
    bx    = sub_i ? ~b_i : b_i;
    // subtraction adds the complement; a borrow-in lowers the injected one
    c0    = sub_i ? ~cin_i : cin_i;
    lo    = {1'b0, a_i[NIB-1:0]} + {1'b0, bx[NIB-1:0]} + {{NIB{1'b0}}, c0};
    hi    = {1'b0, a_i[W-1:NIB]} + {1'b0, bx[W-1:NIB]} + {{HI{1'b0}}, lo[NIB]};
    res_o = {hi[HI-1:0], lo[NIB-1:0]};
    hc_o  = lo[NIB];
    cy_o  = sub_i ? ~hi[HI] : hi[HI];
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
  parameter int W = 8
) (
  input  acc_alu_pkg::alu_op_e op_i,
  input  logic [W-1:0]         a_i,
  input  logic [W-1:0]         b_i,
  output logic [W-1:0]         res_o,
  output logic                 ac_o
);
  import acc_alu_pkg::*;

  always_comb begin
    unique case (op_i)
      OP_AND:  begin res_o = a_i & b_i; ac_o = 1'b1; end
      OP_XOR:  begin res_o = a_i ^ b_i; ac_o = 1'b0; end
      default: begin res_o = a_i | b_i; ac_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/acc_alu_cond.sv
module acc_alu_cond #(
  parameter int W = 8
) (
  input  logic [W-1:0] res_i,
  output logic         z_o,
  output logic         s_o,
  output logic         p_o
);
  always_comb begin
    z_o = (res_i == '0);
    s_o = res_i[W-1];
    p_o = ~(^res_i);
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         exec_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] opnd_i,
  input  logic         cin_i,
  output logic [W-1:0] acc_o,
  output logic         sf_o,
  output logic         zf_o,
  output logic         acf_o,
  output logic         pf_o,
  output logic         cy_o,
  output logic [7:0]   flags_o
);
  import acc_alu_pkg::*;

  alu_op_e      op;
  logic         is_sub, is_logic, use_cin;
  logic [W-1:0] acc_q, a_res, l_res, res;
  logic         a_cy, a_hc, l_ac;
  logic         n_z, n_s, n_p;
  flags_t       fl_q, fl_n;

  always_comb begin
    op       = alu_op_e'(op_i);
    is_sub   = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
    is_logic = (op == OP_AND) || (op == OP_XOR) || (op == OP_OR);
    use_cin  = (op == OP_ADC) || (op == OP_SBB);
  end

  acc_alu_arith #(.W(W), .NIB(NIB)) u_arith (
    .a_i(acc_q), .b_i(opnd_i), .sub_i(is_sub), .cin_i(use_cin & cin_i),
    .res_o(a_res), .cy_o(a_cy), .hc_o(a_hc)
  );

  acc_alu_logic #(.W(W)) u_logic (
    .op_i(op), .a_i(acc_q), .b_i(opnd_i), .res_o(l_res), .ac_o(l_ac)
  );

  assign res = is_logic ? l_res : a_res;

  acc_alu_cond #(.W(W)) u_cond (
    .res_i(res), .z_o(n_z), .s_o(n_s), .p_o(n_p)
  );

  always_comb begin
    fl_n.s  = n_s;
    fl_n.z  = n_z;
    fl_n.p  = n_p;
    fl_n.ac = is_logic ? l_ac : a_hc;
    fl_n.cy = is_logic ? 1'b0 : a_cy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      fl_q  <= '0;
    end else if (exec_i) begin
      if (op != OP_CMP) acc_q <= res;
      fl_q <= fl_n;
    end
  end

  assign acc_o   = acc_q;
  assign sf_o    = fl_q.s;
  assign zf_o    = fl_q.z;
  assign acf_o   = fl_q.ac;
  assign pf_o    = fl_q.p;
  assign cy_o    = fl_q.cy;
  assign flags_o = {fl_q.s, fl_q.z, 1'b0, fl_q.ac, 1'b0, fl_q.p, 1'b1, fl_q.cy};

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !exec_i |=> ($stable(acc_o) && $stable(flags_o))); // R2
  AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
    (exec_i && op_i == 3'd7) |=> acc_o == $past(acc_o)); // R6
  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    (exec_i && op_i[2] && op_i != 3'd7) |=> !cy_o); // R5
  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (exec_i && op_i != 3'd7) |=> (zf_o == (acc_o == '0))); // R7
  AST_SIGN_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (exec_i && op_i != 3'd7) |=> (sf_o == acc_o[W-1])); // R7
  AST_PARITY_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (exec_i && op_i != 3'd7) |=> (pf_o == ~(^acc_o))); // R7
endmodule

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       exec_i = 1'b0;
  logic [2:0] op_i = 3'd0;
  logic [7:0] opnd_i = 8'd0;
  logic       cin_i = 1'b0;
  logic [7:0] acc_o, flags_o;
  logic       sf_o, zf_o, acf_o, pf_o, cy_o;

  int errors = 0;
  int checks = 0;
  logic [7:0] m_acc;
  logic [7:0] m_fl;

  always #10 clk = ~clk;

  acc_alu u0 (
    .clk(clk), .rst(rst), .exec_i(exec_i), .op_i(op_i), .opnd_i(opnd_i),
    .cin_i(cin_i), .acc_o(acc_o), .sf_o(sf_o), .zf_o(zf_o), .acf_o(acf_o),
    .pf_o(pf_o), .cy_o(cy_o), .flags_o(flags_o)
  );

  // returns {new accumulator, flag byte}
  function automatic logic [15:0] model(input logic [7:0] a, input logic [2:0] op,
                                        input logic [7:0] b, input logic ci);
    logic [8:0] s9;
    logic [4:0] h5;
    logic [7:0] r;
    logic cy, ac, bi;
    case (op)
      3'd0, 3'd1: begin
        bi = (op == 3'd1) ? ci : 1'b0;
        s9 = {1'b0, a} + {1'b0, b} + {8'd0, bi};
        h5 = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, bi};
        r = s9[7:0]; cy = s9[8]; ac = h5[4];
      end
      3'd2, 3'd3, 3'd7: begin
        bi = (op == 3'd3) ? ci : 1'b0;
        r  = a - b - {7'd0, bi};
        cy = ({1'b0, a} < ({1'b0, b} + {8'd0, bi}));
        h5 = {1'b0, a[3:0]} + {1'b0, ~b[3:0]} + {4'd0, ~bi};
        ac = h5[4];
      end
      3'd4: begin r = a & b; cy = 1'b0; ac = 1'b1; end
      3'd5: begin r = a ^ b; cy = 1'b0; ac = 1'b0; end
      default: begin r = a | b; cy = 1'b0; ac = 1'b0; end
    endcase
    model = {(op == 3'd7) ? a : r,
             r[7], (r == 8'd0), 1'b0, ac, 1'b0, ~(^r), 1'b1, cy};
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic pins_ok(input string tag);
    chk(tag, {8'd0, flags_o}, {8'd0, sf_o, zf_o, 1'b0, acf_o, 1'b0, pf_o, 1'b1, cy_o});
  endtask

  task automatic run(input string tag, input logic [2:0] op, input logic [7:0] b, input logic ci);
    logic [15:0] e;
    @(negedge clk);
    exec_i = 1'b1; op_i = op; opnd_i = b; cin_i = ci;
    e = model(m_acc, op, b, ci);
    @(negedge clk);
    exec_i = 1'b0;
    m_acc = e[15:8]; m_fl = e[7:0];
    chk(tag, {acc_o, flags_o}, e);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_acc = 8'h00; m_fl = 8'h02;
    chk("R1 reset state", {acc_o, flags_o}, 16'h0002);

    run("R5 OR load", 3'd6, 8'hFF, 1'b0);
    run("R3 add wrap carry", 3'd0, 8'h01, 1'b0);       // FF+1 -> 00, Z CY AC
    chk("R7 zero after wrap", {15'd0, zf_o}, 16'd1);
    run("R5 OR 0F", 3'd6, 8'h0F, 1'b0);
    run("R3 half carry", 3'd0, 8'h01, 1'b0);           // 0F+1 -> 10, AC
    run("R3 adc with cin", 3'd1, 8'h05, 1'b1);
    run("R9 add ignores cin", 3'd0, 8'h01, 1'b1);
    run("R4 sub borrow", 3'd2, 8'h80, 1'b0);
    run("R4 sbb with borrow", 3'd3, 8'h10, 1'b1);
    run("R9 sub ignores cin", 3'd2, 8'h01, 1'b1);
    run("R6 compare equal", 3'd7, m_acc, 1'b0);
    run("R6 compare less", 3'd7, 8'hFF, 1'b1);
    run("R5 AND sets AC", 3'd4, 8'h3C, 1'b0);
    run("R5 XOR clears AC", 3'd5, 8'hA5, 1'b1);
    pins_ok("R8 packed byte");

    // R2: inputs change while exec_i is low
    @(negedge clk);
    op_i = 3'd0; opnd_i = 8'h77; cin_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 idle hold", {acc_o, flags_o}, {m_acc, m_fl});

    for (int i = 0; i < 400; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      run($sformatf("R3 R4 R5 R6 R7 random %0d", i), rv[2:0], rv[15:8], rv[16]);
      if (i % 25 == 0) pins_ok("R8 random");
    end

    // R1: reset coincides with an execute strobe
    run("R5 OR nonzero", 3'd6, 8'h81, 1'b0);
    @(negedge clk);
    rst = 1'b1; exec_i = 1'b1; op_i = 3'd0; opnd_i = 8'h05;
    @(negedge clk);
    rst = 1'b0; exec_i = 1'b0;
    chk("R1 reset beats exec", {acc_o, flags_o}, 16'h0002);
    m_acc = 8'h00; m_fl = 8'h02;
    run("R9 logic ignores cin", 3'd6, 8'h00, 1'b1);
    chk("R7 parity of zero", {15'd0, pf_o}, 16'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule